// File: doc/BRIEF.md
# Comparator Control and Interrupt Register

This block is the digital side of an analog voltage comparator. It holds one byte-wide control and status register. It takes the comparator's raw, asynchronous result and passes it through a flop chain into the clock domain. It watches the synchronized level for the edge kind chosen in a two-bit mode field, and it keeps a sticky interrupt flag. It also drives the pins that power the comparator down, choose its positive input and route its result to a timer's capture trigger.

Software programs the register through a plain write strobe with a byte of data, and reads it back on a combinational read bus. The interrupt controller sees a level request. That request is qualified by a global enable. When the matching vector is taken, the controller pulses an acknowledge that clears the flag. The analog comparator, the reference voltage, the negative-input selection and the capture unit all lie outside this block. None of the interfaces carries a data stream, so every pin is a plain control or status signal without a handshake.

Top module: `cmp_ctrl_reg`

## Requirements
- R1: The register fields sit at fixed bit positions: [7] power-down, [6] reference select, [5] comparator level, [4] interrupt flag, [3] interrupt enable, [2] capture routing, [1:0] event mode. A write stores bits 7, 6, 3, 2, 1 and 0, and these read back unchanged on the next cycle.
- R2: After reset, every register bit reads 0, and all four outputs are 0.
- R3: Bit 5 shows the raw comparator input after a two-flop synchronizer. A change on the input, set up before a clock edge, appears on bit 5 two edges later. A write has no effect on bit 5.
- R4: Event mode 2'b11 sets the flag on a 0-to-1 change of the synchronized level. Mode 2'b10 sets it on a 1-to-0 change. A change in the other direction does not set the flag in either mode. The flag becomes 1 one edge after the change shows on bit 5.
- R5: Event modes 2'b00 and 2'b01 both set the flag on any change of the synchronized level.
- R6: The flag clears on the edge where irq_ack_i is high, or on a write with bit 4 = 1. A write with bit 4 = 0 leaves the flag unchanged.
- R7: When a detected event and a clear fall on the same edge, the flag ends up set.
- R8: irq_o is high exactly when the flag, the interrupt enable bit and gie_i are all 1.
- R9: cmp_pwr_off_o follows bit 7, and cmp_pos_bg_o follows bit 6.
- R10: cap_trig_o equals the synchronized level while bit 2 is 1, and it is 0 while bit 2 is 0.
- R11: While bit 7 is 1, the synchronizer input is held low. From the third edge after bit 7 is set, bit 5 reads 0 whatever the raw input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| cmp_raw_i | input | 1 | Raw, asynchronous comparator result |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt vector acknowledge pulse |
| cmp_pwr_off_o | output | 1 | Comparator power-down |
| cmp_pos_bg_o | output | 1 | Positive input: 1 = fixed reference, 0 = external pin |
| cap_trig_o | output | 1 | Comparator result routed to the timer capture trigger |
| irq_o | output | 1 | Interrupt request |

## Verification
All of the block's state is visible on the read bus, so a wrong value in any control flop shows up there one cycle after the write. A fault in the synchronizer or the history flop shows up as bit 5 changing one edge early or late. It can also show up as the flag setting on the wrong edge direction, within three cycles of the raw input changing. A wrong priority between setting and clearing shows up only in the cycle where an acknowledge meets an event, so the bench holds the acknowledge high across edge events to catch it.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;

  localparam int unsigned REG_W     = 8;
  localparam int unsigned BIT_DIS   = 7;
  localparam int unsigned BIT_BG    = 6;
  localparam int unsigned BIT_LVL   = 5;
  localparam int unsigned BIT_FLAG  = 4;
  localparam int unsigned BIT_IE    = 3;
  localparam int unsigned BIT_CAP   = 2;
  localparam int unsigned BIT_MODE1 = 1;
  localparam int unsigned BIT_MODE0 = 0;

  typedef enum logic [1:0] {
    EV_TOGGLE = 2'b00,
    EV_RSVD   = 2'b01,
    EV_FALL   = 2'b10,
    EV_RISE   = 2'b11
  } ev_mode_e;

  typedef struct packed {
    logic     dis;
    logic     bg;
    logic     ie;
    logic     cap;
    ev_mode_e mode;
  } ctrl_t;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= 1'b0;
          else        stage_q[gi] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= 1'b0;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     level_i,
  input  ev_mode_e mode_i,
  output logic     event_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  always_comb begin
    unique case (mode_i)
      EV_FALL: event_o = prev_q & ~level_i;
      EV_RISE: event_o = level_i & ~prev_q;
      default: event_o = level_i ^ prev_q;
    endcase
  end
endmodule

// File: rtl/cmp_irq_flag.sv
module cmp_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmp_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             cmp_raw_i,
  input  logic             gie_i,
  input  logic             irq_ack_i,
  output logic             cmp_pwr_off_o,
  output logic             cmp_pos_bg_o,
  output logic             cap_trig_o,
  output logic             irq_o
);
  ctrl_t ctrl_q;
  logic  sync_in;
  logic  cmp_level;
  logic  ev_hit;
  logic  flag_clr;
  logic  flag_q;
  logic  unused_wbit;

  // control fields: level bit (read-only) and flag bit (clear-on-one) are excluded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (reg_wr_i) begin
      ctrl_q.dis  <= reg_wdata_i[BIT_DIS];
      ctrl_q.bg   <= reg_wdata_i[BIT_BG];
      ctrl_q.ie   <= reg_wdata_i[BIT_IE];
      ctrl_q.cap  <= reg_wdata_i[BIT_CAP];
      ctrl_q.mode <= ev_mode_e'(reg_wdata_i[BIT_MODE1:BIT_MODE0]);
    end
  end

  assign unused_wbit = reg_wdata_i[BIT_LVL];

  // a powered-down comparator is seen as a steady low
  assign sync_in = cmp_raw_i & ~ctrl_q.dis;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sync_in),
    .q_o   (cmp_level)
  );

  cmp_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (cmp_level),
    .mode_i  (ctrl_q.mode),
    .event_o (ev_hit)
  );

  assign flag_clr = irq_ack_i | (reg_wr_i & reg_wdata_i[BIT_FLAG]);

  cmp_irq_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ev_hit),
    .clr_i  (flag_clr),
    .flag_o (flag_q)
  );

  always_comb begin
    reg_rdata_o                       = '0;
    reg_rdata_o[BIT_DIS]              = ctrl_q.dis;
    reg_rdata_o[BIT_BG]               = ctrl_q.bg;
    reg_rdata_o[BIT_LVL]              = cmp_level;
    reg_rdata_o[BIT_FLAG]             = flag_q;
    reg_rdata_o[BIT_IE]               = ctrl_q.ie;
    reg_rdata_o[BIT_CAP]              = ctrl_q.cap;
    reg_rdata_o[BIT_MODE1:BIT_MODE0]  = ctrl_q.mode;
  end

  assign cmp_pwr_off_o = ctrl_q.dis;
  assign cmp_pos_bg_o  = ctrl_q.bg;
  assign cap_trig_o    = ctrl_q.cap & cmp_level;
  assign irq_o         = flag_q & ctrl_q.ie & gie_i;
endmodule

// File: rtl/cmp_ctrl_reg_chk.sv
module cmp_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       gie_i,
  input logic       irq_ack_i,
  input logic       cmp_pwr_off_o,
  input logic       cmp_pos_bg_o,
  input logic       cap_trig_o,
  input logic       irq_o
);
  logic       lvl_b, flag_b, ie_b, cap_b, dis_b;
  logic [1:0] mode_b;
  assign dis_b  = reg_rdata_o[7];
  assign lvl_b  = reg_rdata_o[5];
  assign flag_b = reg_rdata_o[4];
  assign ie_b   = reg_rdata_o[3];
  assign cap_b  = reg_rdata_o[2];
  assign mode_b = reg_rdata_o[1:0];

  assert_rise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == 2'b11 && $rose(lvl_b)) |=> flag_b);
  assert_fall_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == 2'b10 && $fell(lvl_b)) |=> flag_b);
  assert_toggle_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_b[1] && !$stable(lvl_b)) |=> flag_b);
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && $stable(lvl_b)) |=> !flag_b);
  assert_w0_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_b && reg_wr_i && !reg_wdata_i[4] && !irq_ack_i) |=> flag_b);
  assert_irq_needs_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_b && ie_b && gie_i));
  assert_irq_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_b && ie_b && gie_i) |-> irq_o);
  assert_ctrl_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i |=> (cmp_pwr_off_o == $past(reg_wdata_i[7]) && cmp_pos_bg_o == $past(reg_wdata_i[6])));
  assert_cap_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_b |-> !cap_trig_o);
  assert_cap_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_b |-> (cap_trig_o == lvl_b));
  assert_dis_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_b && $past(dis_b) && $past(dis_b, 2)) |-> !lvl_b);
endmodule

bind cmp_ctrl_reg cmp_ctrl_reg_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr_i      (reg_wr_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .gie_i         (gie_i),
  .irq_ack_i     (irq_ack_i),
  .cmp_pwr_off_o (cmp_pwr_off_o),
  .cmp_pos_bg_o  (cmp_pos_bg_o),
  .cap_trig_o    (cap_trig_o),
  .irq_o         (irq_o)
);

// File: tb/cmp_ctrl_reg_tb.sv
`timescale 1ns/1ps
module cmp_ctrl_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       cmp_raw_i = 1'b0;
  logic       gie_i = 1'b0;
  logic       irq_ack_i = 1'b0;
  logic       cmp_pwr_off_o, cmp_pos_bg_o, cap_trig_o, irq_o;

  always #2.5 clk = ~clk;

  cmp_ctrl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .cmp_raw_i(cmp_raw_i), .gie_i(gie_i),
    .irq_ack_i(irq_ack_i), .cmp_pwr_off_o(cmp_pwr_off_o), .cmp_pos_bg_o(cmp_pos_bg_o),
    .cap_trig_o(cap_trig_o), .irq_o(irq_o)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  bit    done   = 0;
  bit    cmp_on = 0;
  string cur_req = "R2";

  // behavioural reference: history of gated raw samples, newest first
  logic hist[$];
  logic m_dis, m_bg, m_ie, m_cap, m_flag;
  logic [1:0] m_mode;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {1'b0, 1'b0, 1'b0};
      m_dis = 0; m_bg = 0; m_ie = 0; m_cap = 0; m_flag = 0; m_mode = 2'b00;
    end else begin
      logic lvl, old, ev;
      lvl = hist[1];
      old = hist[2];
      case (m_mode)
        2'b11:   ev = lvl && !old;
        2'b10:   ev = !lvl && old;
        default: ev = lvl != old;
      endcase
      if (ev) m_flag = 1;
      else if (irq_ack_i || (reg_wr_i && reg_wdata_i[4])) m_flag = 0;
      hist.push_front(cmp_raw_i && !m_dis);
      void'(hist.pop_back());
      if (reg_wr_i) begin
        m_dis = reg_wdata_i[7]; m_bg = reg_wdata_i[6]; m_ie = reg_wdata_i[3];
        m_cap = reg_wdata_i[2]; m_mode = reg_wdata_i[1:0];
      end
    end
  end

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(cur_req, "rdata", reg_rdata_o, {m_dis, m_bg, hist[1], m_flag, m_ie, m_cap, m_mode});
      check("R8", "irq", {7'd0, irq_o}, {7'd0, m_flag & m_ie & gie_i});
      check("R9", "pins", {6'd0, cmp_pwr_off_o, cmp_pos_bg_o}, {6'd0, m_dis, m_bg});
      check("R10", "cap", {7'd0, cap_trig_o}, {7'd0, m_cap & hist[1]});
    end
  end

  task automatic drive(input logic wr, input logic [7:0] wd, input logic raw,
                       input logic g, input logic ack);
    @(negedge clk);
    #1;
    reg_wr_i = wr; reg_wdata_i = wd; cmp_raw_i = raw; gie_i = g; irq_ack_i = ack;
  endtask

  task automatic idle(input int n, input logic raw, input logic g);
    for (int i = 0; i < n; i++) drive(0, 8'h00, raw, g, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    // R2: reset state
    check("R2", "reset rdata", reg_rdata_o, 8'h00);
    check("R2", "reset outs", {4'd0, cmp_pwr_off_o, cmp_pos_bg_o, cap_trig_o, irq_o}, 8'h00);
    cmp_on = 1;

    cur_req = "R1";   // writable fields read back, R3: bit 5 written high is ignored
    drive(1, 8'h6F, 0, 0, 0); idle(2, 0, 0);
    drive(1, 8'h20, 0, 0, 0); idle(2, 0, 0);
    cur_req = "R3";
    drive(1, 8'h0C, 1, 1, 0); idle(4, 1, 1); idle(4, 0, 1);

    cur_req = "R5";   // toggle and reserved modes
    drive(1, 8'h18, 0, 1, 0); idle(3, 1, 1); drive(0, 0, 1, 1, 1); idle(3, 0, 1);
    drive(1, 8'h19, 0, 1, 0); idle(3, 1, 1); drive(0, 0, 1, 1, 1); idle(3, 0, 1);

    cur_req = "R4";   // rising then falling mode, wrong direction ignored
    drive(1, 8'h1B, 0, 1, 0); idle(3, 1, 1); drive(0, 0, 1, 1, 1); idle(4, 0, 1); idle(3, 1, 1);
    drive(1, 8'h1A, 1, 1, 0); idle(3, 0, 1); drive(1, 8'h1A, 0, 1, 0); idle(3, 1, 1); idle(3, 0, 1);

    cur_req = "R6";   // write zero keeps, write one clears
    drive(1, 8'h0A, 0, 1, 0); idle(2, 0, 1); drive(1, 8'h1A, 0, 1, 0); idle(2, 0, 1);

    cur_req = "R7";   // acknowledge held across an event
    drive(1, 8'h0B, 0, 1, 1); for (int i = 0; i < 5; i++) drive(0, 0, 1, 1, 1); idle(3, 1, 1);

    cur_req = "R8";
    drive(0, 0, 1, 0, 0); idle(2, 1, 0); drive(1, 8'h03, 1, 1, 0); idle(2, 1, 1);

    cur_req = "R11";  // powered down with raw high
    drive(1, 8'hC4, 1, 1, 0); idle(6, 1, 1); drive(1, 8'h04, 1, 1, 0); idle(5, 1, 1);

    cur_req = "R7";   // pseudo-random mix of everything
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[3:0] == 4'h0, {lfsr[11] & lfsr[12], lfsr[13:7]}, lfsr[5] ^ lfsr[17],
            lfsr[20] | lfsr[21], lfsr[25:23] == 3'b000);
    end
    idle(3, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule